// File: doc/BRIEF.md
# Display Timing Controller Register Bank

This block stores the programmable settings of a display timing controller and makes them reachable through a two-port I/O window: one port holds an index, the port right above it carries the data of the register that index selects. The window sits at one of two base addresses. An input taken from the miscellaneous output register picks the base, so software that sets the adapter to colour or monochrome addressing sees the bank move with it.

Besides register storage, the bank turns its contents into values that the display pipeline uses directly: cursor shape, a 16-bit display start address, a 16-bit cursor location, the character cell height and the vertical display end as a line count. A protect bit in one control register locks the low timing registers against writes, so that a stray mode change cannot break the sync timing.

Top module: `crtc_bank`

## Requirements
- R1: The index port decodes at `COLOR_BASE` (0x03D4) when `color_sel` is 1 and at `MONO_BASE` (0x03B4) when it is 0; the data port is the index port address plus one.
- R2: A write to any address other than the selected index or data port changes nothing, and a read there returns 0xFF.
- R3: A read of the index port returns the full 8-bit value last written to it.
- R4: The bank holds 25 registers at indices 0x00 to 0x18; a data-port write stores into the indexed register and a data-port read returns it; with an index above 0x18, data writes are dropped and data reads return 0x00.
- R5: `cursor_start` and `cursor_end` show registers 0x0A and 0x0B.
- R6: `start_addr` is register 0x0C (high byte) above register 0x0D (low byte); `cursor_loc` is register 0x0E (high byte) above register 0x0F (low byte).
- R7: `max_scan` shows bits 4:0 of register 0x09; bits 7:5 of that register are stored and read back unchanged and do not affect `max_scan`.
- R8: `vert_disp_end` equals register 0x12 plus 256 when register 0x07 bit 1 is set plus 512 when register 0x07 bit 6 is set, plus one.
- R9: While bit 7 of register 0x11 is 1, data writes to indices 0x00 to 0x07 leave them unchanged, except that bit 4 of register 0x07 still takes the written value; writing 0x00 to register 0x11 lifts the lock.
- R10: Reset clears all 25 registers and the index, so after reset `vert_disp_end` is 1 and every other derived output is 0.
- R11: A write changes the stored state and the derived outputs at the next rising clock edge; reads are combinational from the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| color_sel | input | 1 | Base select from the miscellaneous output register: 1 colour, 0 monochrome |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cursor_start | output | 8 | Cursor start register |
| cursor_end | output | 8 | Cursor end register |
| start_addr | output | 16 | Display start address |
| cursor_loc | output | 16 | Cursor location |
| max_scan | output | 5 | Maximum scan line (cell height minus one) |
| vert_disp_end | output | 11 | Vertical display end as a line count |

## Verification
Every write lands on the first rising edge after the strobe is driven, and the derived outputs follow from the stored registers without another stage, so both the stored value and the outputs are due one edge after the write. The bench drives on falling edges, holds each write for exactly one edge, and samples outputs at the following falling edge; reads settle within the same cycle the address is applied and are sampled a short delay after driving it. The protection cases read back through the data port after each blocked write, so a wrongly accepted write shows up in the next check.

// File: rtl/crtc_bank_pkg.sv
package crtc_bank_pkg;

  // Register positions the derived outputs depend on
  localparam int IDX_PROT_LAST = 8'h07;
  localparam int IDX_OVERFLOW  = 8'h07;
  localparam int IDX_CELL      = 8'h09;
  localparam int IDX_CUR_TOP   = 8'h0A;
  localparam int IDX_CUR_BOT   = 8'h0B;
  localparam int IDX_START_HI  = 8'h0C;
  localparam int IDX_START_LO  = 8'h0D;
  localparam int IDX_CLOC_HI   = 8'h0E;
  localparam int IDX_CLOC_LO   = 8'h0F;
  localparam int IDX_LOCK      = 8'h11;
  localparam int IDX_VDE_LO    = 8'h12;
  localparam int LOCK_BIT      = 7;
  localparam int OPEN_BIT      = 4;

  typedef struct packed {
    logic hit;
    logic idx_sel;
    logic dat_sel;
  } port_dec_t;

  // Line count from the low byte and the overflow register
  function automatic logic [10:0] vde_lines(input logic [7:0] lo, input logic [7:0] ovf);
    return {1'b0, ovf[6], ovf[1], lo} + 11'd1;
  endfunction

  // Bitwise merge: bits set in mask take the new value
  function automatic logic [7:0] merge_bits(input logic [7:0] old_v, input logic [7:0] new_v,
                                            input logic [7:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/crtc_port_decode.sv
module crtc_port_decode
  import crtc_bank_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] COLOR_BASE = 16'h03D4,
  parameter logic [15:0] MONO_BASE  = 16'h03B4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              color_sel,
  output port_dec_t         dec
);
  logic [ADDR_W-1:0] base;

  always_comb begin
    base        = color_sel ? ADDR_W'(COLOR_BASE) : ADDR_W'(MONO_BASE);
    dec.idx_sel = (addr == base);
    dec.dat_sel = (addr == base + ADDR_W'(1));
    dec.hit     = dec.idx_sel | dec.dat_sel;
  end
endmodule

// File: rtl/crtc_reg_store.sv
module crtc_reg_store
  import crtc_bank_pkg::*;
#(
  parameter int NUM_REGS = 25,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            idx_we,
  input  logic                            dat_we,
  input  logic [DATA_W-1:0]               wdata,
  output logic [IDX_W-1:0]                idx_q,
  output logic                            prot_on,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= IDX_W'(wdata);
  end

  assign prot_on = regs[IDX_LOCK][LOCK_BIT];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] OPEN_MASK =
      (i == IDX_OVERFLOW) ? (DATA_W'(1) << OPEN_BIT) : '0;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] wmask;
    logic              sel;

    assign sel   = dat_we && (idx_q == IDX_W'(i));
    assign wmask = (prot_on && (i <= IDX_PROT_LAST)) ? OPEN_MASK : '1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (sel) q <= merge_bits(q, wdata, wmask);
    end

    assign regs[i] = q;
  end
endmodule

// File: rtl/crtc_derive.sv
module crtc_derive
  import crtc_bank_pkg::*;
#(
  parameter int NUM_REGS = 25,
  parameter int DATA_W   = 8
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  output logic [7:0]                      cursor_start,
  output logic [7:0]                      cursor_end,
  output logic [15:0]                     start_addr,
  output logic [15:0]                     cursor_loc,
  output logic [4:0]                      max_scan,
  output logic [10:0]                     vert_disp_end
);
  assign cursor_start  = regs[IDX_CUR_TOP];
  assign cursor_end    = regs[IDX_CUR_BOT];
  assign start_addr    = {regs[IDX_START_HI], regs[IDX_START_LO]};
  assign cursor_loc    = {regs[IDX_CLOC_HI], regs[IDX_CLOC_LO]};
  assign max_scan      = regs[IDX_CELL][4:0];
  assign vert_disp_end = vde_lines(regs[IDX_VDE_LO], regs[IDX_OVERFLOW]);
endmodule

// File: rtl/crtc_bank.sv
module crtc_bank
  import crtc_bank_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          NUM_REGS   = 25,
  parameter logic [15:0] COLOR_BASE = 16'h03D4,
  parameter logic [15:0] MONO_BASE  = 16'h03B4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        color_sel,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [7:0]  cursor_start,
  output logic [7:0]  cursor_end,
  output logic [15:0] start_addr,
  output logic [15:0] cursor_loc,
  output logic [4:0]  max_scan,
  output logic [10:0] vert_disp_end
);
  localparam int DATA_W = 8;
  localparam int IDX_W  = 8;

  port_dec_t                        dec;
  logic                             addr_hit;
  logic                             idx_we;
  logic                             dat_we;
  logic [IDX_W-1:0]                 idx_q;
  logic                             prot_on;
  logic [NUM_REGS-1:0][DATA_W-1:0]  regs;

  crtc_port_decode #(
    .ADDR_W(ADDR_W), .COLOR_BASE(COLOR_BASE), .MONO_BASE(MONO_BASE)
  ) u_dec (
    .addr(bus_addr[ADDR_W-1:0]), .color_sel(color_sel), .dec(dec)
  );

  assign addr_hit = dec.hit;
  assign idx_we   = bus_wr && dec.idx_sel;
  assign dat_we   = bus_wr && dec.dat_sel;

  crtc_reg_store #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we),
    .wdata(bus_wdata), .idx_q(idx_q), .prot_on(prot_on), .regs(regs)
  );

  crtc_derive #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
  ) u_derive (
    .regs(regs), .cursor_start(cursor_start), .cursor_end(cursor_end),
    .start_addr(start_addr), .cursor_loc(cursor_loc),
    .max_scan(max_scan), .vert_disp_end(vert_disp_end)
  );

  // Read path: miss -> all ones, index port -> index, data port -> register
  logic [DATA_W-1:0] sel_reg;
  always_comb begin
    sel_reg = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx_q == IDX_W'(i)) sel_reg = regs[i];
  end

  always_comb begin
    if (!dec.hit)        bus_rdata = 8'hFF;
    else if (dec.idx_sel) bus_rdata = idx_q;
    else                 bus_rdata = sel_reg;
  end
endmodule

// File: rtl/crtc_bank_checks.sv
module crtc_bank_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        addr_hit,
  input logic        idx_we,
  input logic        dat_we,
  input logic [7:0]  idx_q,
  input logic        prot_on,
  input logic [7:0]  cursor_start,
  input logic [4:0]  max_scan,
  input logic [10:0] vert_disp_end
);
  AST_MISS_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> bus_rdata == 8'hFF);                                        // R2
  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !addr_hit) |=> $stable(idx_q));                                 // R2
  AST_INDEX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> idx_q == $past(bus_wdata));                                     // R3
  AST_CURSOR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && idx_q == 8'h0A) |=> cursor_start == $past(bus_wdata));          // R5
  AST_CELL_HEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && idx_q == 8'h09) |=> max_scan == $past(bus_wdata[4:0]));         // R7
  AST_LOCKED_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && prot_on && idx_q == 8'h07) |=> $stable(vert_disp_end));         // R9
endmodule

bind crtc_bank crtc_bank_checks u_checks (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .addr_hit(addr_hit), .idx_we(idx_we), .dat_we(dat_we),
  .idx_q(idx_q), .prot_on(prot_on), .cursor_start(cursor_start),
  .max_scan(max_scan), .vert_disp_end(vert_disp_end)
);

// File: tb/crtc_bank_test.sv
module crtc_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CBASE = 16'h03D4;
  localparam logic [15:0] MBASE = 16'h03B4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        color_sel = 1'b1;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [7:0]  cursor_start, cursor_end;
  logic [15:0] start_addr, cursor_loc;
  logic [4:0]  max_scan;
  logic [10:0] vert_disp_end;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crtc_bank uut (
    .clk(clk), .rst_n(rst_n), .color_sel(color_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cursor_start(cursor_start), .cursor_end(cursor_end),
    .start_addr(start_addr), .cursor_loc(cursor_loc),
    .max_scan(max_scan), .vert_disp_end(vert_disp_end)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic reg_write(input logic [15:0] base, input logic [7:0] idx, input logic [7:0] d);
    io_write(base, idx);
    io_write(base + 16'd1, d);
  endtask

  task automatic reg_read(input logic [15:0] base, input logic [7:0] idx, output logic [7:0] d);
    io_write(base, idx);
    io_read(base + 16'd1, d);
  endtask

  function automatic logic [10:0] exp_vde(input logic [7:0] lo, input logic [7:0] ovf);
    int n;
    n = lo + 1;
    if (ovf[1]) n += 256;
    if (ovf[6]) n += 512;
    return n[10:0];
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    check("R10 vde after reset", vert_disp_end, 11'd1);
    check("R10 start_addr", start_addr, 16'h0);
    check("R10 cursor_loc", cursor_loc, 16'h0);
    io_read(CBASE, d);
    check("R10 index cleared", d, 8'h00);
    reg_read(CBASE, 8'h11, d);
    check("R10 lock reg cleared", d, 8'h00);
  endtask

  task automatic t_decode;
    logic [7:0] d;
    color_sel = 1'b1;
    reg_write(CBASE, 8'h0A, 8'h0D);
    check("R1 R5 cursor_start via colour base", cursor_start, 8'h0D);
    color_sel = 1'b0;
    reg_write(MBASE, 8'h0B, 8'h0E);
    check("R1 R5 cursor_end via mono base", cursor_end, 8'h0E);
    reg_read(MBASE, 8'h0A, d);
    check("R1 R4 mono data readback", d, 8'h0D);
    io_read(CBASE, d);
    check("R2 unselected colour index reads FF", d, 8'hFF);
    io_write(CBASE + 16'd1, 8'h77);
    check("R2 write at unselected base ignored", cursor_start, 8'h0D);
    io_read(MBASE, d);
    check("R2 R3 index kept after miss", d, 8'h0A);
    io_read(16'h03C0, d);
    check("R2 unrelated address reads FF", d, 8'hFF);
    color_sel = 1'b1;
    io_read(MBASE + 16'd1, d);
    check("R2 unselected mono data reads FF", d, 8'hFF);
  endtask

  task automatic t_index_range;
    logic [7:0] d;
    io_write(CBASE, 8'hA5);
    io_read(CBASE, d);
    check("R3 index readback full byte", d, 8'hA5);
    reg_write(CBASE, 8'h18, 8'h3C);
    reg_read(CBASE, 8'h18, d);
    check("R4 last register 0x18", d, 8'h3C);
    reg_write(CBASE, 8'h19, 8'h99);
    io_read(CBASE + 16'd1, d);
    check("R4 out-of-range index reads 0", d, 8'h00);
    reg_read(CBASE, 8'h00, d);
    check("R4 out-of-range write did not hit reg 0", d, 8'h00);
  endtask

  task automatic t_addresses;
    reg_write(CBASE, 8'h0C, 8'h12);
    reg_write(CBASE, 8'h0D, 8'h34);
    check("R6 start_addr", start_addr, 16'h1234);
    reg_write(CBASE, 8'h0E, 8'hAB);
    reg_write(CBASE, 8'h0F, 8'hCD);
    check("R6 cursor_loc", cursor_loc, 16'hABCD);
  endtask

  task automatic t_cell;
    logic [7:0] d;
    reg_write(CBASE, 8'h09, 8'hE7);
    check("R7 max_scan low bits", max_scan, 5'h07);
    reg_read(CBASE, 8'h09, d);
    check("R7 upper bits kept", d, 8'hE7);
    reg_write(CBASE, 8'h09, 8'h1F);
    check("R7 max_scan all ones", max_scan, 5'h1F);
  endtask

  task automatic t_vde;
    reg_write(CBASE, 8'h12, 8'hDF);
    check("R8 vde no overflow", vert_disp_end, exp_vde(8'hDF, 8'h00));
    reg_write(CBASE, 8'h07, 8'h02);
    check("R8 vde bit8", vert_disp_end, exp_vde(8'hDF, 8'h02));
    reg_write(CBASE, 8'h07, 8'h42);
    check("R8 vde bits 8 and 9", vert_disp_end, exp_vde(8'hDF, 8'h42));
    reg_write(CBASE, 8'h12, 8'hFF);
    check("R8 vde maximum", vert_disp_end, 11'd1024);
  endtask

  task automatic t_protect;
    logic [7:0] d;
    reg_write(CBASE, 8'h07, 8'h00);
    reg_write(CBASE, 8'h00, 8'h5F);
    reg_write(CBASE, 8'h11, 8'h80);
    reg_write(CBASE, 8'h00, 8'h11);
    reg_read(CBASE, 8'h00, d);
    check("R9 locked reg 0 unchanged", d, 8'h5F);
    reg_write(CBASE, 8'h07, 8'hFF);
    reg_read(CBASE, 8'h07, d);
    check("R9 locked reg 7 only bit 4", d, 8'h10);
    check("R9 vde unaffected by locked write", vert_disp_end, exp_vde(8'hFF, 8'h00));
    reg_write(CBASE, 8'h08, 8'h33);
    reg_read(CBASE, 8'h08, d);
    check("R9 reg 8 open while locked", d, 8'h33);
    reg_write(CBASE, 8'h11, 8'h00);
    reg_write(CBASE, 8'h07, 8'h42);
    reg_read(CBASE, 8'h07, d);
    check("R9 unlocked reg 7 writable", d, 8'h42);
    reg_write(CBASE, 8'h00, 8'h66);
    reg_read(CBASE, 8'h00, d);
    check("R9 unlocked reg 0 writable", d, 8'h66);
  endtask

  task automatic t_timing;
    // R11: update lands on the edge after the strobe, not before
    io_write(CBASE, 8'h0A);
    @(negedge clk);
    bus_addr = CBASE + 16'd1; bus_wdata = 8'h2A; bus_wr = 1'b1;
    #1 check("R11 no update before edge", cursor_start, 8'h0D);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R11 update after one edge", cursor_start, 8'h2A);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_index_range();
    t_addresses();
    t_cell();
    t_vde();
    t_protect();
    t_timing();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end
endmodule